// File: doc/BRIEF.md
# Escape-Coded MFM Write Stream Interpreter

This block sits between a DMA engine that supplies 16-bit write words and the bit-level MFM encoder of a floppy disk controller. Every accepted word is read in one of two ways. If its upper byte is not the escape value 0x99, the word is two plain data bytes. If its upper byte is 0x99, the lower byte is a command. The commands emit sync marks with a suppressed clock, emit the address or data mark byte, open a window in which escape detection is switched off, insert the running CRC, or end the write.

Bytes go to the encoder one at a time. Each byte carries a flag that says whether it is plain data or a mark that must be written with a missing clock. The encoder pulls a byte with a one-cycle request. If a request finds no byte ready, the write is aborted with an underrun error. A CRC-16 runs alongside the stream. It is preset at the first sync mark of a group, so the CRC for a sector covers the marks, the mark byte and the sector data.

Top module: `mfm_wsi_interp`

## Requirements
- R1: After reset `writing`, `enc_valid`, `in_ready` and `underrun_err` are 0. A one-cycle `wr_start` sets `writing` and clears `underrun_err` on the next cycle. It also empties the output byte, presets the CRC to 0xFFFF and closes any escape-free window.
- R2: An accepted word whose upper byte is not 0x99 yields two plain bytes (`enc_mark`=0): first the upper byte, then the lower byte.
- R3: Word 0x99A1 yields one byte 0xA1 with `enc_mark`=1. Word 0x99C2 yields one byte 0xC2 with `enc_mark`=1. `enc_mark` is only ever 1 on those two byte values.
- R4: Word 0x99FE yields one plain byte 0xFE. Word 0x99FB yields one plain byte 0xFB.
- R5: The CRC uses polynomial 0x1021, processed MSB first from bit 7 of each byte. An A1 word that does not directly follow another accepted A1 word presets the CRC to 0xFFFF before the A1 is folded in. Every byte emitted for R2, for A1 and for R4 updates the CRC. C2 marks and inserted CRC bytes do not update it.
- R6: Word 0x9904 yields two plain bytes: the CRC's upper byte first, then its lower byte. The value is the CRC over everything accepted before this word.
- R7: Word 0x990F emits nothing. The next RAW_WORDS accepted words (default 256, i.e. 512 bytes) are treated as R2 data whatever their upper byte. After that window, escapes are decoded again.
- R8: Word 0x9908 emits nothing. It clears `writing`, pulses `wr_done` for one cycle, and no further word is accepted.
- R9: A 0x99 word with any lower byte other than A1, C2, FE, FB, 04, 0F or 08 sets `underrun_err`, clears `writing` and emits nothing.
- R10: An `enc_req` while `writing` is 1 and `enc_valid` is 0 sets `underrun_err` and clears `writing`.
- R11: `in_ready` is 1 only while writing, either when no byte is held and no request is pending, or when the last held byte is taken in this cycle. With a request every second cycle and words always offered, a stream runs without underrun.
- R12: While `writing` is 0, `enc_req` has no effect: no byte is presented and `underrun_err` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | One-cycle pulse that begins a write operation |
| in_word | input | 16 | Write word from the DMA stream |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Word is taken when high together with `in_valid` |
| enc_req | input | 1 | Encoder takes the presented byte this cycle |
| enc_byte | output | 8 | Byte presented to the encoder |
| enc_mark | output | 1 | Presented byte is a missing-clock mark |
| enc_valid | output | 1 | A byte is presented |
| writing | output | 1 | Write operation in progress |
| wr_done | output | 1 | One-cycle pulse when a stop command ends the write |
| underrun_err | output | 1 | Sticky error: underrun or undefined command |

## Verification
Each of the 256 possible command bytes is placed after the escape, between two plain data words. The emitted byte sequence, mark flags and end status then separate the seven defined commands from one another, and from the undefined codes that must abort the write. A sweep over all 255 non-escape upper-byte values shows that only 0x99 is treated as an escape. A full sector of preamble, 512 data bytes containing escape values, and postamble checks three things: the escape-free window length, CRC preset at the sync group, and CRC insertion order. A short stream with two sync groups and an index mark separates the preset rule from the C2 exclusion. An empty stream shows the underrun abort, and requests held after each stop show they are ignored.

// File: rtl/mfm_wsi_pkg.sv
// Shared constants, decoded-action type and CRC step for the write stream
// interpreter. Assumes MSB-first CRC-16 with polynomial 0x1021.
package mfm_wsi_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CRC_W  = 16;

    localparam logic [BYTE_W-1:0] ESC_CODE  = 8'h99;
    localparam logic [BYTE_W-1:0] CMD_SYNC  = 8'hA1;
    localparam logic [BYTE_W-1:0] CMD_INDEX = 8'hC2;
    localparam logic [BYTE_W-1:0] CMD_AMARK = 8'hFE;
    localparam logic [BYTE_W-1:0] CMD_DMARK = 8'hFB;
    localparam logic [BYTE_W-1:0] CMD_RAW   = 8'h0F;
    localparam logic [BYTE_W-1:0] CMD_CRC   = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_STOP  = 8'h08;

    localparam logic [CRC_W-1:0] CRC_POLY   = 16'h1021;
    localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;

    // Decoded meaning of one accepted write word.
    typedef struct packed {
        logic [1:0]        nbytes;   // bytes to emit (0..2)
        logic [BYTE_W-1:0] b0;       // first byte out
        logic [BYTE_W-1:0] b1;       // second byte out
        logic              mark;     // first byte is a missing-clock mark
        logic              crc_upd;  // emitted bytes feed the CRC
        logic              sync;     // word is a sync mark
        logic              open_raw; // opens the escape-free window
        logic              stop;     // ends the write
        logic              bad;      // undefined command
    } wsi_act_t;

    // One byte of CRC-16, MSB first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i]) r = {r[CRC_W-2:0], 1'b0} ^ CRC_POLY;
            else                   r = {r[CRC_W-2:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/mfm_wsi_decode.sv
// Classifies one write word into an action. Purely combinational.
// Assumes the caller supplies the current CRC for the insert command and
// whether the escape-free window is open.
module mfm_wsi_decode
    import mfm_wsi_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              raw_active,
    input  logic [CRC_W-1:0]  crc_now,
    output wsi_act_t          act
);
    logic [BYTE_W-1:0] hi, lo;
    assign hi = word[WORD_W-1:BYTE_W];
    assign lo = word[BYTE_W-1:0];

    // Map the word onto bytes to emit and control effects.
    always_comb begin
        act = '0;
        if (raw_active || hi != ESC_CODE) begin
            act.nbytes  = 2'd2;
            act.b0      = hi;
            act.b1      = lo;
            act.crc_upd = 1'b1;
        end else begin
            unique case (lo)
                CMD_SYNC: begin
                    act.nbytes  = 2'd1;
                    act.b0      = lo;
                    act.mark    = 1'b1;
                    act.crc_upd = 1'b1;
                    act.sync    = 1'b1;
                end
                CMD_INDEX: begin
                    act.nbytes = 2'd1;
                    act.b0     = lo;
                    act.mark   = 1'b1;
                end
                CMD_AMARK, CMD_DMARK: begin
                    act.nbytes  = 2'd1;
                    act.b0      = lo;
                    act.crc_upd = 1'b1;
                end
                CMD_CRC: begin
                    act.nbytes = 2'd2;
                    act.b0     = crc_now[CRC_W-1:BYTE_W];
                    act.b1     = crc_now[BYTE_W-1:0];
                end
                CMD_RAW:  act.open_raw = 1'b1;
                CMD_STOP: act.stop     = 1'b1;
                default:  act.bad      = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/mfm_wsi_crc.sv
// Running CRC-16 register. Folds one or two bytes per enable, optionally
// starting from the preset value. Assumes nbytes is 1 or 2 when en is high.
module mfm_wsi_crc
    import mfm_wsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic              preset,
    input  logic [1:0]        nbytes,
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    output logic [CRC_W-1:0]  crc
);
    logic [CRC_W-1:0] base, one, two;

    // Next value after the first and second byte.
    always_comb begin
        base = preset ? CRC_PRESET : crc;
        one  = crc_step(base, b0);
        two  = crc_step(one, b1);
    end

    // CRC register update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= CRC_PRESET;
        else if (en)         crc <= (nbytes == 2'd2) ? two : one;
    end
endmodule

// File: rtl/mfm_wsi_rawwin.sv
// Counts the words left in the escape-free window. Assumes a word is taken
// at most once per cycle.
module mfm_wsi_rawwin #(
    parameter int RAW_WORDS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic open_win,
    input  logic take,
    output logic active
);
    localparam int CW = $clog2(RAW_WORDS + 1);
    localparam logic [CW-1:0] FULL = CW'(RAW_WORDS);

    logic [CW-1:0] left;

    // Load on open, count down per accepted word while open.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)    left <= '0;
        else if (open_win)      left <= FULL;
        else if (take && active) left <= left - 1'b1;
    end

    assign active = (left != '0);
endmodule

// File: rtl/mfm_wsi_outq.sv
// Two-byte output holder toward the encoder. Only the first byte of a load
// may be a mark. Assumes load only when empty or when the last byte pops.
module mfm_wsi_outq
    import mfm_wsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [1:0]        nbytes,
    input  logic [BYTE_W-1:0] b0,
    input  logic [BYTE_W-1:0] b1,
    input  logic              mark0,
    input  logic              pop,
    output logic [1:0]        cnt,
    output logic [BYTE_W-1:0] head,
    output logic              head_mark
);
    logic [BYTE_W-1:0] s0, s1;
    logic              m0;

    // Load a decoded word or shift out the head byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
            s0  <= '0;
            s1  <= '0;
            m0  <= 1'b0;
        end else if (load) begin
            s0  <= b0;
            s1  <= b1;
            m0  <= mark0;
            cnt <= nbytes;
        end else if (pop) begin
            s0  <= s1;
            m0  <= 1'b0;
            cnt <= cnt - 1'b1;
        end
    end

    assign head      = s0;
    assign head_mark = m0 && (cnt != '0);
endmodule

// File: rtl/mfm_wsi_interp.sv
// Top of the write stream interpreter. Accepts 16-bit words, decodes escape
// commands, keeps the sector CRC and feeds tagged bytes to the encoder.
// Assumes the encoder pulls at most one byte per cycle via enc_req.
module mfm_wsi_interp
    import mfm_wsi_pkg::*;
#(
    parameter int RAW_WORDS = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              enc_req,
    output logic [BYTE_W-1:0] enc_byte,
    output logic              enc_mark,
    output logic              enc_valid,
    output logic              writing,
    output logic              wr_done,
    output logic              underrun_err
);
    wsi_act_t         act;
    logic             raw_active;
    logic [CRC_W-1:0] crc_now;
    logic [1:0]       q_cnt;
    logic             accept, pop, starve, q_load, last_sync;

    mfm_wsi_decode dec_i (
        .word      (in_word),
        .raw_active(raw_active),
        .crc_now   (crc_now),
        .act       (act)
    );

    mfm_wsi_rawwin #(.RAW_WORDS(RAW_WORDS)) raw_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_start),
        .open_win(accept && act.open_raw),
        .take    (accept),
        .active  (raw_active)
    );

    mfm_wsi_crc crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (wr_start),
        .en    (accept && act.crc_upd),
        .preset(act.sync && !last_sync),
        .nbytes(act.nbytes),
        .b0    (act.b0),
        .b1    (act.b1),
        .crc   (crc_now)
    );

    mfm_wsi_outq q_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wr_start),
        .load     (q_load),
        .nbytes   (act.nbytes),
        .b0       (act.b0),
        .b1       (act.b1),
        .mark0    (act.mark),
        .pop      (pop),
        .cnt      (q_cnt),
        .head     (enc_byte),
        .head_mark(enc_mark)
    );

    // Handshake and pull decisions for this cycle.
    always_comb begin
        enc_valid = (q_cnt != 2'd0);
        pop       = writing && enc_req && enc_valid;
        starve    = writing && enc_req && !enc_valid;
        in_ready  = writing && !wr_start &&
                    ((q_cnt == 2'd0 && !enc_req) || (q_cnt == 2'd1 && enc_req));
        accept    = in_valid && in_ready;
        q_load    = accept && !act.bad && !act.stop && (act.nbytes != 2'd0);
    end

    // Write-operation state, error flag, done pulse and sync-run tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            writing      <= 1'b0;
            underrun_err <= 1'b0;
            wr_done      <= 1'b0;
            last_sync    <= 1'b0;
        end else begin
            wr_done <= 1'b0;
            if (wr_start) begin
                writing      <= 1'b1;
                underrun_err <= 1'b0;
                last_sync    <= 1'b0;
            end else if (starve) begin
                writing      <= 1'b0;
                underrun_err <= 1'b1;
            end else if (accept) begin
                last_sync <= act.sync;
                if (act.bad) begin
                    writing      <= 1'b0;
                    underrun_err <= 1'b1;
                end else if (act.stop) begin
                    writing <= 1'b0;
                    wr_done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mfm_wsi_chk.sv
// Property checker for the write stream interpreter, bound to the top.
module mfm_wsi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_start,
    input logic       in_ready,
    input logic       enc_req,
    input logic [7:0] enc_byte,
    input logic       enc_mark,
    input logic       enc_valid,
    input logic       writing,
    input logic       wr_done,
    input logic       underrun_err
);
    // R12
    idle_no_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !writing |-> !enc_valid);

    // R11
    ready_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> writing);

    // R10
    underrun_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (writing && enc_req && !enc_valid && !wr_start) |=> (underrun_err && !writing));

    // R8
    done_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> !writing);

    // R3
    mark_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_mark |-> (enc_valid && (enc_byte == 8'hA1 || enc_byte == 8'hC2)));

    // R1
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> (writing && !underrun_err));
endmodule

bind mfm_wsi_interp mfm_wsi_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_start    (wr_start),
    .in_ready    (in_ready),
    .enc_req     (enc_req),
    .enc_byte    (enc_byte),
    .enc_mark    (enc_mark),
    .enc_valid   (enc_valid),
    .writing     (writing),
    .wr_done     (wr_done),
    .underrun_err(underrun_err)
);

// File: tb/mfm_wsi_interp_tb_top.sv
`timescale 1ns/1ps
module mfm_wsi_interp_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAWW       = 256;
    localparam int MAXN       = 1024;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        enc_req = 1'b0;
    logic [7:0]  enc_byte;
    logic        enc_mark;
    logic        enc_valid;
    logic        writing;
    logic        wr_done;
    logic        underrun_err;

    int checks = 0;
    int errors = 0;

    // Stimulus list and expected results from the requirement model
    logic [15:0] stim [MAXN];
    int          stim_n;
    logic [7:0]  exp_b [MAXN];
    logic        exp_m [MAXN];
    int          exp_n;
    logic [7:0]  cap_b [MAXN];
    logic        cap_m [MAXN];
    int          cap_n;
    bit          done_seen;

    // Requirement model state
    int          m_raw;
    logic [15:0] m_crc;
    bit          m_last, m_live, m_err, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfm_wsi_interp #(.RAW_WORDS(RAWW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .enc_req(enc_req), .enc_byte(enc_byte), .enc_mark(enc_mark),
        .enc_valid(enc_valid), .writing(writing), .wr_done(wr_done),
        .underrun_err(underrun_err)
    );

    function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            r = (r[15] ^ b[i]) ? ((r << 1) ^ 16'h1021) : (r << 1);
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act_v, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act_v, exp_v);
        end
    endtask

    task automatic clear_model();
        stim_n = 0; exp_n = 0;
        m_raw = 0; m_crc = 16'hFFFF; m_last = 0;
        m_live = 1; m_err = 0; m_done = 0;
    endtask

    task automatic emit(input logic [7:0] b, input bit mk, input bit upd);
        exp_b[exp_n] = b; exp_m[exp_n] = mk; exp_n++;
        if (upd) m_crc = bcrc(m_crc, b);
    endtask

    // Append a word and derive its expected effect from R2..R9
    task automatic add_word(input logic [15:0] w);
        bit is_sync;
        stim[stim_n] = w; stim_n++;
        if (!m_live) return;
        is_sync = 0;
        if (m_raw > 0 || w[15:8] != 8'h99) begin
            emit(w[15:8], 0, 1); emit(w[7:0], 0, 1);
            if (m_raw > 0) m_raw--;
        end else begin
            case (w[7:0])
                8'hA1: begin
                    if (!m_last) m_crc = 16'hFFFF;
                    emit(8'hA1, 1, 1); is_sync = 1;
                end
                8'hC2: emit(8'hC2, 1, 0);
                8'hFE, 8'hFB: emit(w[7:0], 0, 1);
                8'h04: begin
                    logic [15:0] t = m_crc;
                    emit(t[15:8], 0, 0); emit(t[7:0], 0, 0);
                end
                8'h0F: m_raw = RAWW;
                8'h08: begin m_live = 0; m_done = 1; end
                default: begin m_live = 0; m_err = 1; end
            endcase
        end
        m_last = is_sync;
    endtask

    // Start a write, stream the list with a request every second cycle,
    // then hold requests for a few idle cycles and compare.
    task automatic run_op(input string tag);
        int idx = 0;
        int cyc = 0;
        bit exp_err;
        cap_n = 0; done_seen = 0;
        exp_err = m_err || m_live;   // still writing at list end -> underrun
        @(negedge clk); wr_start = 1; enc_req = 0; in_valid = 0;
        @(negedge clk); wr_start = 0;
        while (cyc < 4000) begin
            enc_req  = (cyc >= 2) && (cyc % 2 == 0);
            in_valid = (idx < stim_n);
            in_word  = in_valid ? stim[idx] : 16'h0;
            #1;
            if (in_valid && in_ready) idx++;
            if (enc_req && enc_valid && cap_n < MAXN) begin
                cap_b[cap_n] = enc_byte; cap_m[cap_n] = enc_mark; cap_n++;
            end
            @(negedge clk); cyc++;
            #1;
            if (wr_done) done_seen = 1;
            if (!writing) break;
        end
        // R12: requests after the write has ended change nothing
        in_valid = 1; in_word = 16'h1234;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); enc_req = 1; #1;
            chk(!enc_valid && !in_ready, "R12", "idle output/ready", enc_valid, 0);
        end
        @(negedge clk); enc_req = 0; in_valid = 0; #1;
        chk(underrun_err == exp_err, (exp_err && !m_err) ? "R10" : tag, "error flag",
            underrun_err, exp_err);
        chk(done_seen == m_done, tag, "done pulse", done_seen, m_done);
        chk(cap_n == exp_n, tag, "byte count", cap_n, exp_n);
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            chk(cap_b[k] == exp_b[k] && cap_m[k] == exp_m[k], tag, $sformatf("byte %0d", k),
                {cap_m[k], cap_b[k]}, {exp_m[k], exp_b[k]});
        end
    endtask

    function automatic string cmd_tag(input logic [7:0] c);
        case (c)
            8'hA1, 8'hC2: return "R3";
            8'hFE, 8'hFB: return "R4";
            8'h04:        return "R6";
            8'h0F:        return "R7";
            8'h08:        return "R8";
            default:      return "R9";
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(!writing && !enc_valid && !in_ready && !underrun_err, "R1", "reset state",
            {writing, enc_valid, in_ready, underrun_err}, 0);
        @(negedge clk); rst_n = 1;

        // R1: start arms the write
        @(negedge clk); wr_start = 1;
        @(negedge clk); wr_start = 0; #1;
        chk(writing && !underrun_err, "R1", "armed after start", {writing, underrun_err}, 2);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;

        // R10: empty stream starves the encoder
        clear_model();
        run_op("R10");

        // R2: every non-escape upper byte passes as data
        clear_model();
        for (int h = 0; h < 256; h++) begin
            if (h != 8'h99) add_word({8'(h), 8'(h) ^ 8'h5A});
        end
        add_word(16'h9908);
        run_op("R2");

        // R3 R4 R6 R7 R8 R9: every command byte after the escape
        for (int c = 0; c < 256; c++) begin
            clear_model();
            add_word(16'h1234);
            add_word({8'h99, 8'(c)});
            add_word(16'h5678);
            add_word(16'h9908);
            run_op(cmd_tag(8'(c)));
        end

        // R5: two sync groups and an index mark outside the CRC
        clear_model();
        add_word(16'h4E4E);
        add_word(16'h99A1); add_word(16'h1111);
        add_word(16'h99A1); add_word(16'h99A1);
        add_word(16'h2222); add_word(16'h99C2); add_word(16'h3333);
        add_word(16'h9904); add_word(16'h9908);
        run_op("R5");

        // R5 R7 R11: full sector with preamble, escaped data and postamble
        clear_model();
        for (int k = 0; k < 5; k++) add_word(16'h4E4E);
        for (int k = 0; k < 6; k++) add_word(16'h0000);
        for (int k = 0; k < 3; k++) add_word(16'h99A1);
        add_word(16'h99FB);
        add_word(16'h990F);
        for (int k = 0; k < RAWW; k++) add_word(16'((k * 16'h3B1) ^ 16'h9908));
        add_word(16'h9904);
        add_word(16'h4E4E); add_word(16'h4E4E);
        add_word(16'h9908);
        for (int k = 0; k < 6; k++) add_word(16'h0000);
        run_op("R7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule